// File: doc/BRIEF.md
# Counted Bitmap Tree Set

This block keeps a set of N elements as a bitmap split into N/W leaf words of W bits, with a binary tree of count nodes above the leaves. Each internal node holds two counts, the number of members in its left subtree and in its right subtree. It holds no child pointers: a node's children follow from its position. Each tree level sits in its own storage bank. A command walks down from the root one level per pipeline stage, so the block takes a new command every cycle.

Four commands exist. Add puts an element in the set. Delete removes it. Test reports whether an element is a member. Find returns some member of the set. Find steers left at every node whose left count is nonzero, so it always returns the lowest-numbered member. Add and Delete move the counts along their path only when the leaf bit really changes. Whether it changes is settled when the command enters, against the leaf bank and against every older Add or Delete still in the pipeline. Since every level is written in command order, a later command always sees the effect of every earlier one.

The command side is a valid/ready stream. `cmd_ready` is high whenever the block is out of reset, so a command is taken on every edge where `cmd_valid` is high. The response side has no ready signal and cannot be stalled: the consumer must take `resp_valid` on the cycle it appears.

Top module: `bitmap_tree`

## Requirements
- R1: During reset `cmd_ready` and `resp_valid` are low. After reset the set is empty.
- R2: Add (opcode 2'b01) makes the element a member. Its response carries `resp_hit` equal to the membership before the command and `resp_index` equal to the command index. Test (opcode 2'b00) returns the current membership in `resp_hit` and echoes the index.
- R3: Delete (opcode 2'b10) removes the element. Its response carries the membership before the command and echoes the index.
- R4: Add on an element that is already a member changes no count, so later Find and Test results are as if the repeat never happened.
- R5: Delete on an element that is not a member changes no count, so later Find and Test results are as if it never happened.
- R6: Find (opcode 2'b11) on a non-empty set returns `resp_hit`=1 and the lowest-numbered member in `resp_index`.
- R7: Find on an empty set returns `resp_hit`=0 and `resp_index`=0.
- R8: `cmd_ready` is high out of reset. Each accepted command yields exactly one response H+1 cycles later (H = log2(N/W)), in command order. `resp_valid` is low in every other cycle.
- R9: Commands issued in consecutive cycles on the same element or the same tree path give the same results as if each had been issued alone, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 00 Test, 01 Add, 10 Delete, 11 Find |
| cmd_index | input | log2(N) | Element index (ignored for Find) |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Membership (Test/Add/Delete, before the command) or found (Find) |
| resp_index | output | log2(N) | Echoed index, or the member found by Find |

## Verification
Every result is due exactly H+1 cycles after the edge that accepts its command. With the default N=256 and W=16 that is 5 cycles. The bench records the accepting edge of each command and expects the matching response in the half cycle after edge accept+5. It reports a response that arrives with nothing due, and also a due slot in which no response arrives. The bound checker delays the accept strobe and the issue-stage decision by fixed shift registers. With these it checks the response timing, and checks that the leaf bit each Add or Delete finds agrees with the count adjustment that was decided when the command entered.

// File: rtl/abt_pkg.sv
package abt_pkg;
  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_ADD  = 2'b01,
    OP_DEL  = 2'b10,
    OP_FIND = 2'b11
  } abt_op_e;
endpackage

// File: rtl/abt_issue.sv
// Entry stage: decides whether an Add/Delete really flips its leaf bit,
// looking at every older command still in flight (newest wins) and the leaf bank.
module abt_issue
  import abt_pkg::*;
#(
  parameter int N = 256,
  parameter int W = 16,
  localparam int NB = $clog2(N),
  localparam int LB = $clog2(W),
  localparam int H  = NB - LB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_v,
  input  logic [1:0]    cmd_op,
  input  logic [NB-1:0] cmd_idx,
  input  logic          peek_bit,
  input  logic          fl_v   [H+1],
  input  logic [1:0]    fl_op  [H+1],
  input  logic [NB-1:0] fl_idx [H+1],
  output logic          o_v,
  output logic [1:0]    o_op,
  output logic [NB-1:0] o_idx,
  output logic [H-1:0]  o_path,
  output logic          o_inc,
  output logic          o_dec
);
  logic eff;

  always_comb begin
    eff = peek_bit;
    for (int k = H; k >= 0; k--) begin
      if (fl_v[k] && (fl_op[k] == OP_ADD || fl_op[k] == OP_DEL) && fl_idx[k] == cmd_idx)
        eff = (fl_op[k] == OP_ADD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_v    <= 1'b0;
      o_op   <= OP_TEST;
      o_idx  <= '0;
      o_path <= '0;
      o_inc  <= 1'b0;
      o_dec  <= 1'b0;
    end else begin
      o_v    <= cmd_v;
      o_op   <= cmd_op;
      o_idx  <= cmd_idx;
      o_path <= (cmd_op == OP_FIND) ? '0 : cmd_idx[NB-1:LB];
      o_inc  <= cmd_v && (cmd_op == OP_ADD) && !eff;
      o_dec  <= cmd_v && (cmd_op == OP_DEL) && eff;
    end
  end
endmodule

// File: rtl/abt_level.sv
// One tree level: a bank of left/right member counts, read and updated by
// the command passing through, which also picks the Find direction here.
module abt_level
  import abt_pkg::*;
#(
  parameter int N   = 256,
  parameter int W   = 16,
  parameter int LVL = 0,
  localparam int NB  = $clog2(N),
  localparam int LB  = $clog2(W),
  localparam int H   = NB - LB,
  localparam int NW  = (LVL == 0) ? 1 : LVL,
  localparam int SEL = H - 1 - LVL,
  localparam int CW  = $clog2((N >> (LVL + 1)) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [1:0]    in_op,
  input  logic [NB-1:0] in_idx,
  input  logic [H-1:0]  in_path,
  input  logic          in_inc,
  input  logic          in_dec,
  input  logic          in_fail,
  output logic          out_v,
  output logic [1:0]    out_op,
  output logic [NB-1:0] out_idx,
  output logic [H-1:0]  out_path,
  output logic          out_inc,
  output logic          out_dec,
  output logic          out_fail
);
  logic [CW-1:0] lcnt [1<<NW];
  logic [CW-1:0] rcnt [1<<NW];
  logic [NW-1:0] node;
  logic [CW-1:0] lc, rc;
  logic          is_find, br;

  always_comb begin
    node    = (LVL == 0) ? '0 : in_path[H-1 -: NW];
    lc      = lcnt[node];
    rc      = rcnt[node];
    is_find = (in_op == OP_FIND);
    br      = is_find ? (lc == '0) : in_path[SEL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < (1 << NW); n++) begin
        lcnt[n] <= '0;
        rcnt[n] <= '0;
      end
      out_v    <= 1'b0;
      out_op   <= OP_TEST;
      out_idx  <= '0;
      out_path <= '0;
      out_inc  <= 1'b0;
      out_dec  <= 1'b0;
      out_fail <= 1'b0;
    end else begin
      out_v         <= in_v;
      out_op        <= in_op;
      out_idx       <= in_idx;
      out_path      <= in_path;
      out_path[SEL] <= br;
      out_inc       <= in_inc;
      out_dec       <= in_dec;
      out_fail      <= in_fail | (is_find && lc == '0 && rc == '0);
      if (in_inc) begin
        if (br) rcnt[node] <= rc + CW'(1);
        else    lcnt[node] <= lc + CW'(1);
      end else if (in_dec) begin
        if (br) rcnt[node] <= rc - CW'(1);
        else    lcnt[node] <= lc - CW'(1);
      end
    end
  end
endmodule

// File: rtl/abt_leaf.sv
// Leaf bank of W-bit words: performs the bit update, answers Test and
// finishes Find with the lowest set bit of the chosen word.
module abt_leaf
  import abt_pkg::*;
#(
  parameter int N = 256,
  parameter int W = 16,
  localparam int NB = $clog2(N),
  localparam int LB = $clog2(W),
  localparam int H  = NB - LB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [1:0]    in_op,
  input  logic [NB-1:0] in_idx,
  input  logic [H-1:0]  in_path,
  input  logic          in_inc,
  input  logic          in_dec,
  input  logic          in_fail,
  input  logic [NB-1:0] peek_idx,
  output logic          peek_bit,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic [NB-1:0] resp_index
);
  logic [W-1:0]  words [1<<H];
  logic [W-1:0]  word;
  logic [LB-1:0] bpos, fpos;
  logic          found;

  always_comb begin
    word  = words[in_path];
    bpos  = in_idx[LB-1:0];
    fpos  = '0;
    for (int j = W - 1; j >= 0; j--) begin
      if (word[j]) fpos = LB'(j);
    end
    found    = !in_fail && (word != '0);
    peek_bit = words[peek_idx[NB-1:LB]][peek_idx[LB-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < (1 << H); n++) words[n] <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_index <= '0;
    end else begin
      resp_valid <= in_v;
      if (in_op == OP_FIND) begin
        resp_hit   <= found;
        resp_index <= found ? {in_path, fpos} : '0;
      end else begin
        resp_hit   <= word[bpos];
        resp_index <= in_idx;
      end
      if (in_inc)      words[in_path][bpos] <= 1'b1;
      else if (in_dec) words[in_path][bpos] <= 1'b0;
    end
  end
endmodule

// File: rtl/bitmap_tree.sv
module bitmap_tree
  import abt_pkg::*;
#(
  parameter int N = 256,
  parameter int W = 16,
  localparam int NB = $clog2(N),
  localparam int LB = $clog2(W),
  localparam int H  = NB - LB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [NB-1:0] cmd_index,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic [NB-1:0] resp_index
);
  // Stage k register set: k=0 is the entry stage, k>0 is the output of level k-1.
  logic          s_v    [H+1];
  logic [1:0]    s_op   [H+1];
  logic [NB-1:0] s_idx  [H+1];
  logic [H-1:0]  s_path [H+1];
  logic          s_inc  [H+1];
  logic          s_dec  [H+1];
  logic          s_fail [H+1];
  logic          peek_bit;

  assign cmd_ready = rst_n;
  assign s_fail[0] = 1'b0;

  abt_issue #(.N(N), .W(W)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .cmd_v(cmd_valid && cmd_ready), .cmd_op(cmd_op), .cmd_idx(cmd_index),
    .peek_bit(peek_bit),
    .fl_v(s_v), .fl_op(s_op), .fl_idx(s_idx),
    .o_v(s_v[0]), .o_op(s_op[0]), .o_idx(s_idx[0]), .o_path(s_path[0]),
    .o_inc(s_inc[0]), .o_dec(s_dec[0])
  );

  for (genvar k = 0; k < H; k++) begin : g_lvl
    abt_level #(.N(N), .W(W), .LVL(k)) u_lvl (
      .clk(clk), .rst_n(rst_n),
      .in_v(s_v[k]), .in_op(s_op[k]), .in_idx(s_idx[k]), .in_path(s_path[k]),
      .in_inc(s_inc[k]), .in_dec(s_dec[k]), .in_fail(s_fail[k]),
      .out_v(s_v[k+1]), .out_op(s_op[k+1]), .out_idx(s_idx[k+1]), .out_path(s_path[k+1]),
      .out_inc(s_inc[k+1]), .out_dec(s_dec[k+1]), .out_fail(s_fail[k+1])
    );
  end

  abt_leaf #(.N(N), .W(W)) u_leaf (
    .clk(clk), .rst_n(rst_n),
    .in_v(s_v[H]), .in_op(s_op[H]), .in_idx(s_idx[H]), .in_path(s_path[H]),
    .in_inc(s_inc[H]), .in_dec(s_dec[H]), .in_fail(s_fail[H]),
    .peek_idx(cmd_index), .peek_bit(peek_bit),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_index(resp_index)
  );
endmodule

// File: rtl/bitmap_tree_chk.sv
module bitmap_tree_chk
  import abt_pkg::*;
#(
  parameter int N = 256,
  parameter int W = 16,
  localparam int H   = $clog2(N) - $clog2(W),
  localparam int LAT = H + 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc,
  input logic       resp_valid,
  input logic       resp_hit,
  input logic       iss_v,
  input logic [1:0] iss_op,
  input logic       iss_inc,
  input logic       iss_dec
);
  logic [LAT:0] acc_q;
  logic [H:0]   add_q, del_q, inc_q, dec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      add_q <= '0;
      del_q <= '0;
      inc_q <= '0;
      dec_q <= '0;
    end else begin
      acc_q <= (acc_q << 1) | (LAT+1)'(acc);
      add_q <= (add_q << 1) | (H+1)'(iss_v && iss_op == OP_ADD);
      del_q <= (del_q << 1) | (H+1)'(iss_v && iss_op == OP_DEL);
      inc_q <= (inc_q << 1) | (H+1)'(iss_inc);
      dec_q <= (dec_q << 1) | (H+1)'(iss_dec);
    end
  end

  a_r8_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == acc_q[LAT]);

  a_r2_add_new_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && add_q[H] && !resp_hit) |-> inc_q[H]);

  a_r4_add_dup_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && add_q[H] && resp_hit) |-> !inc_q[H]);

  a_r3_del_member_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && del_q[H] && resp_hit) |-> dec_q[H]);

  a_r5_del_absent_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && del_q[H] && !resp_hit) |-> !dec_q[H]);
endmodule

bind bitmap_tree bitmap_tree_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(cmd_valid && cmd_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit),
  .iss_v(s_v[0]), .iss_op(s_op[0]), .iss_inc(s_inc[0]), .iss_dec(s_dec[0])
);

// File: tb/bitmap_tree_tb.sv
`timescale 1ns/1ps
module bitmap_tree_tb;
  localparam int N   = 256;
  localparam int W   = 16;
  localparam int NB  = $clog2(N);
  localparam int LAT = $clog2(N / W) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [NB-1:0] cmd_index = '0;
  logic          cmd_ready, resp_valid, resp_hit;
  logic [NB-1:0] resp_index;

  bitmap_tree #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_index(cmd_index),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_index(resp_index)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    model [N];
  int    q_due [$];
  bit    q_hit [$];
  int    q_idx [$];
  string q_tag [$];
  int    m_due, m_idx;
  bit    m_hit;
  string m_tag;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Response monitor, sampling away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resp_valid) begin
        if (q_due.size() == 0) begin
          check(1'b0, "R8", "response with nothing due", 1, 0);
        end else begin
          m_due = q_due.pop_front();
          m_hit = q_hit.pop_front();
          m_idx = q_idx.pop_front();
          m_tag = q_tag.pop_front();
          checks++;
          if (m_due != cyc || resp_hit != m_hit || int'(resp_index) != m_idx) begin
            fails++;
            $display("FAIL %s: actual hit=%0b idx=%0d cycle=%0d expected hit=%0b idx=%0d cycle=%0d",
                     m_tag, resp_hit, resp_index, cyc, m_hit, m_idx, m_due);
          end
        end
      end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
        m_due = q_due.pop_front();
        void'(q_hit.pop_front());
        void'(q_idx.pop_front());
        m_tag = q_tag.pop_front();
        check(1'b0, m_tag, "missing response at cycle", cyc, m_due);
      end
    end
  end

  // Opcodes: 0 Test, 1 Add, 2 Delete, 3 Find.
  task automatic issue(input int op, input int idx, input string tag);
    bit eh = 1'b0;
    int ei = idx;
    case (op)
      0: eh = model[idx];
      1: begin eh = model[idx]; model[idx] = 1'b1; end
      2: begin eh = model[idx]; model[idx] = 1'b0; end
      default: begin
        ei = 0;
        for (int j = N - 1; j >= 0; j--) if (model[j]) begin eh = 1'b1; ei = j; end
      end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op[1:0];
    cmd_index = idx[NB-1:0];
    q_due.push_back(cyc + 1 + LAT);
    q_hit.push_back(eh);
    q_idx.push_back(ei);
    q_tag.push_back(tag);
  endtask

  task automatic settle();
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    check(q_due.size() == 0, "R8", "responses still outstanding", q_due.size(), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
    check(cmd_ready == 1'b0, "R1", "cmd_ready in reset", cmd_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8", "cmd_ready after reset", cmd_ready, 1);
    issue(3, 0, "R7 find on empty set after reset");
    issue(0, 5, "R1 test after reset");
    settle();
  endtask

  task automatic t_add_test();
    issue(1, 37, "R2 add new member");
    settle();
    issue(0, 37, "R2 test member");
    issue(0, 36, "R2 test neighbour");
    settle();
  endtask

  task automatic t_delete();
    issue(2, 37, "R3 delete member");
    settle();
    issue(0, 37, "R3 test after delete");
    issue(3, 0, "R7 find after last delete");
    settle();
  endtask

  task automatic t_dup_add();
    issue(1, 200, "R4 add");
    issue(1, 200, "R4 add repeat");
    settle();
    issue(2, 200, "R4 delete");
    issue(1, 250, "R4 add other");
    settle();
    issue(3, 0, "R4 find after repeated add");
    issue(0, 200, "R4 test");
    settle();
    issue(2, 250, "R4 cleanup");
    settle();
  endtask

  task automatic t_dup_del();
    issue(2, 10, "R5 delete absent");
    issue(1, 130, "R5 add");
    settle();
    issue(3, 0, "R5 find after absent delete");
    issue(2, 130, "R5 cleanup");
    settle();
    issue(3, 0, "R7 find empty again");
    settle();
  endtask

  task automatic t_find_order();
    issue(1, 77, "R6 add");
    issue(1, 190, "R6 add");
    issue(1, 3, "R6 add");
    settle();
    issue(3, 0, "R6 find lowest");
    issue(2, 3, "R6 delete");
    issue(3, 0, "R6 find next");
    issue(1, 66, "R6 add same word");
    issue(1, 65, "R6 add same word");
    issue(3, 0, "R6 find within word");
    settle();
    issue(2, 65, "R6 delete"); issue(2, 66, "R6 delete"); issue(2, 77, "R6 delete");
    issue(2, 190, "R6 delete");
    issue(1, 255, "R6 add top index");
    issue(3, 0, "R6 find top index");
    issue(2, 255, "R6 delete top");
    issue(1, 0, "R6 add index 0");
    issue(3, 0, "R6 find index 0");
    issue(2, 0, "R6 delete index 0");
    issue(3, 0, "R7 find emptied set");
    settle();
  endtask

  task automatic t_back_to_back();
    issue(1, 9, "R9 add");
    issue(2, 9, "R9 delete next cycle");
    issue(1, 9, "R9 add again");
    issue(0, 9, "R9 test");
    issue(3, 0, "R9 find right after");
    issue(1, 8, "R9 same word");
    issue(2, 9, "R9 delete");
    issue(3, 0, "R9 find same path");
    issue(2, 8, "R9 delete");
    issue(3, 0, "R9 find empty");
    settle();
  endtask

  task automatic t_stream();
    int unsigned st = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      st = st * 32'd1103515245 + 32'd12345;
      issue(int'((st >> 16) & 3), int'((st >> 20) & 32'h1F) + 96 * int'((st >> 27) & 1),
            "R8 R9 mixed stream");
    end
    settle();
    for (int j = 0; j < N; j++) if (model[j]) issue(2, j, "R3 drain");
    issue(3, 0, "R7 find after drain");
    settle();
  endtask

  initial begin
    t_reset();
    t_add_test();
    t_delete();
    t_dup_add();
    t_dup_del();
    t_find_order();
    t_back_to_back();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule